// File: doc/BRIEF.md
# Write-completion status poller

This engine sits on the host side of an asynchronous byte-wide non-volatile memory bus. It accepts a write request through a valid/ready handshake and drives one byte or a run of bytes onto the bus as write strobes. It then waits a settle period and issues repeated ordinary read cycles until the returned status bits show that the memory has finished its internal programming phase. All bus timing is counted in clock cycles and set by parameters.

Two completion methods can be selected per request. The data-bit method keeps the last written byte and reads its address back until bit 7 of the returned byte agrees with bit 7 of the written byte. The toggle-bit method compares bit 6 of each read with bit 6 of the read before it and finishes on the first pair that agrees. A poll limit captured with the request bounds the number of reads. When the limit is reached a one-cycle timeout pulse ends the operation. A successful end produces a one-cycle done pulse. In both cases the engine is ready again in the same cycle.

The first handshake beat of a request carries the start address, first byte, byte count, method and poll limit. Every later beat of the same request carries only the next data byte.

Top module: `nvm_write_poller`

## Requirements
- R1: After reset, reqReady is 1, memCeN, memOeN and memWeN are all 1, and done and timeout are 0.
- R2: Each byte is written by holding memCeN and memWeN at 0 with memOeN at 1 for PULSE_CYC cycles while memAddr and memDout hold the byte's address and data. memWeN then stays at 1 for RECOV_CYC cycles while memCeN stays at 0 and address and data are unchanged.
- R3: A request with reqCount = N (1 to 2^PAGE_W) writes N bytes. Each byte after the first is taken on a further handshake beat. Each byte goes to the previous address plus one in the low PAGE_W bits, wrapping within the page, and the upper address bits do not change.
- R4: The first status read begins exactly RECOV_CYC + SETTLE_CYC cycles after memWeN rises at the end of the last byte.
- R5: Each status read holds memCeN and memOeN at 0 with memWeN at 1 for READ_CYC cycles at the last written address. Consecutive reads are separated by GAP_CYC cycles with all strobes at 1.
- R6: With reqMethod = 0 (data-bit method), the operation completes on the first read whose bit 7 equals bit 7 of the last written byte.
- R7: With reqMethod = 1 (toggle-bit method), the operation completes on the first read whose bit 6 equals bit 6 of the read before it in the same operation. The first read never completes the operation.
- R8: If pollLimit reads have all failed the completion test, timeout pulses instead of done, and no further read is issued. A limit of 0 behaves as 1.
- R9: done and timeout are one-cycle pulses, at most one of them per operation. reqReady is 1 in the cycle either pulse is high.
- R10: memWeN and memOeN are never both 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request beat valid |
| reqReady | output | 1 | Engine can take a beat (idle or between page bytes) |
| reqAddr | input | ADDR_W | Start address, first beat only |
| reqData | input | DATA_W | Byte to write on this beat |
| reqCount | input | PAGE_W+1 | Number of bytes, first beat only |
| reqMethod | input | 1 | 0 = data-bit method, 1 = toggle-bit method |
| pollLimit | input | POLL_W | Maximum number of status reads |
| memAddr | output | ADDR_W | Bus address |
| memDout | output | DATA_W | Bus write data |
| memDin | input | DATA_W | Bus read data |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| done | output | 1 | One-cycle pulse: programming seen complete |
| timeout | output | 1 | One-cycle pulse: poll limit reached |

## Verification
A stale saved byte or an incorrect method flag shows up as a wrong read count. The done pulse arrives one or more read cycles early or late, or a timeout replaces it, within the first few polls of that request. A wrong address increment shows in the model memory contents and in the address of the first status read. A miscounted timer changes the strobe widths or the settle gap on the very first byte, and the bus monitor measures these to the cycle.

// File: rtl/nvm_poll_pkg.sv
package nvm_poll_pkg;

  // which interval the shared down-counter is loaded with
  typedef enum logic [2:0] {
    TM_PULSE,
    TM_RECOV,
    TM_SETTLE,
    TM_READ,
    TM_GAP
  } tmrSel_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic    ldReq;
    logic    ldByte;
    logic    tmrLoad;
    tmrSel_e tmrSel;
    logic    sample;
    logic    incPoll;
    logic    setDone;
    logic    setTimeout;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLOW,
    ST_WHIGH,
    ST_WAITB,
    ST_SETTLE,
    ST_RACC,
    ST_RGAP
  } busState_e;

endpackage

// File: rtl/nvm_poll_dp.sv
module nvm_poll_dp
  import nvm_poll_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int POLL_W     = 16,
  parameter int TMR_W      = 16,
  parameter int PULSE_CYC  = 3,
  parameter int RECOV_CYC  = 2,
  parameter int SETTLE_CYC = 20,
  parameter int READ_CYC   = 2,
  parameter int GAP_CYC    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [PAGE_W:0]   reqCount,
  input  logic              reqMethod,
  input  logic [POLL_W-1:0] pollLimit,
  input  logic [1:0]        statusBits,   // {bit7, bit6} of the read data
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] curData,
  output logic              timerZero,
  output logic              lastByte,
  output logic              statusOk,
  output logic              pollLast,
  output logic              doneQ,
  output logic              timeoutQ
);

  localparam int CNT_W = PAGE_W + 1;
  localparam logic [TMR_W-1:0] PULSE_LD  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] RECOV_LD  = TMR_W'(RECOV_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] READ_LD   = TMR_W'(READ_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD    = TMR_W'(GAP_CYC - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [CNT_W-1:0]  remQ;
  logic              methodQ;
  logic [POLL_W-1:0] limitQ;
  logic [POLL_W-1:0] pollCnt;
  logic [TMR_W-1:0]  tmrQ;
  logic [TMR_W-1:0]  tmrNext;
  logic              prevBit6;
  logic              havePrev;

  always_comb begin
    case (ctl.tmrSel)
      TM_PULSE:  tmrNext = PULSE_LD;
      TM_RECOV:  tmrNext = RECOV_LD;
      TM_SETTLE: tmrNext = SETTLE_LD;
      TM_READ:   tmrNext = READ_LD;
      default:   tmrNext = GAP_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      remQ     <= '0;
      methodQ  <= 1'b0;
      limitQ   <= '0;
      pollCnt  <= '0;
      tmrQ     <= '0;
      prevBit6 <= 1'b0;
      havePrev <= 1'b0;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      doneQ    <= ctl.setDone;
      timeoutQ <= ctl.setTimeout;
      if (ctl.ldReq) begin
        addrQ    <= reqAddr;
        dataQ    <= reqData;
        remQ     <= reqCount;
        methodQ  <= reqMethod;
        limitQ   <= pollLimit;
        pollCnt  <= '0;
        havePrev <= 1'b0;
      end else if (ctl.ldByte) begin
        // page address stays put, only the in-page offset advances
        addrQ <= {addrQ[ADDR_W-1:PAGE_W], addrQ[PAGE_W-1:0] + 1'b1};
        dataQ <= reqData;
        remQ  <= remQ - 1'b1;
      end
      if (ctl.tmrLoad)       tmrQ <= tmrNext;
      else if (tmrQ != '0)   tmrQ <= tmrQ - 1'b1;
      if (ctl.sample) begin
        prevBit6 <= statusBits[0];
        havePrev <= 1'b1;
      end
      if (ctl.incPoll) pollCnt <= pollCnt + 1'b1;
    end
  end

  assign curAddr   = addrQ;
  assign curData   = dataQ;
  assign timerZero = (tmrQ == '0);
  assign lastByte  = (remQ <= CNT_W'(1));
  assign statusOk  = methodQ ? (havePrev && (statusBits[0] == prevBit6))
                             : (statusBits[1] == dataQ[DATA_W-1]);
  assign pollLast  = ({1'b0, pollCnt} + 1'b1) >= {1'b0, limitQ};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);  // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && timeoutQ));  // R8
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldByte |=> $stable(addrQ[ADDR_W-1:PAGE_W]));  // R3

endmodule

// File: rtl/nvm_poll_ctrl.sv
module nvm_poll_ctrl
  import nvm_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       timerZero,
  input  logic       lastByte,
  input  logic       statusOk,
  input  logic       pollLast,
  output ctlStrobe_t ctl,
  output logic       reqReady,
  output logic       memCeN,
  output logic       memOeN,
  output logic       memWeN
);

  busState_e state;
  busState_e nxt;

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.tmrSel = TM_PULSE;
    case (state)
      ST_IDLE: if (reqValid) begin
        ctl.ldReq = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_PULSE;
        nxt = ST_WLOW;
      end
      ST_WLOW: if (timerZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_RECOV;
        nxt = ST_WHIGH;
      end
      ST_WHIGH: if (timerZero) begin
        if (lastByte) begin
          ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_SETTLE;
          nxt = ST_SETTLE;
        end else begin
          nxt = ST_WAITB;
        end
      end
      ST_WAITB: if (reqValid) begin
        ctl.ldByte = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_PULSE;
        nxt = ST_WLOW;
      end
      ST_SETTLE: if (timerZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_READ;
        nxt = ST_RACC;
      end
      ST_RACC: if (timerZero) begin
        ctl.sample = 1'b1;
        if (statusOk) begin
          ctl.setDone = 1'b1;
          nxt = ST_IDLE;
        end else if (pollLast) begin
          ctl.setTimeout = 1'b1;
          nxt = ST_IDLE;
        end else begin
          ctl.incPoll = 1'b1; ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_GAP;
          nxt = ST_RGAP;
        end
      end
      ST_RGAP: if (timerZero) begin
        ctl.tmrLoad = 1'b1; ctl.tmrSel = TM_READ;
        nxt = ST_RACC;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign reqReady = (state == ST_IDLE) || (state == ST_WAITB);
  assign memCeN   = !((state == ST_WLOW) || (state == ST_WHIGH) || (state == ST_RACC));
  assign memWeN   = (state != ST_WLOW);
  assign memOeN   = (state != ST_RACC);

  AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> (!memWeN && !memCeN && memOeN));  // R2
  AST_OK_ENDS_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACC && timerZero && statusOk) |=> (reqReady && memOeN));  // R9
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memOeN) |-> $past(memWeN));  // R10

endmodule

// File: rtl/nvm_write_poller.sv
module nvm_write_poller
  import nvm_poll_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int POLL_W     = 16,
  parameter int TMR_W      = 16,
  parameter int PULSE_CYC  = 3,
  parameter int RECOV_CYC  = 2,
  parameter int SETTLE_CYC = 20,
  parameter int READ_CYC   = 2,
  parameter int GAP_CYC    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [PAGE_W:0]   reqCount,
  input  logic              reqMethod,
  input  logic [POLL_W-1:0] pollLimit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              done,
  output logic              timeout
);

  ctlStrobe_t ctl;
  logic timerZero, lastByte, statusOk, pollLast;
  logic unusedDin;

  assign unusedDin = ^memDin[DATA_W-3:0];

  nvm_poll_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .timerZero(timerZero), .lastByte(lastByte),
    .statusOk(statusOk), .pollLast(pollLast),
    .ctl(ctl), .reqReady(reqReady),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN)
  );

  nvm_poll_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .POLL_W(POLL_W),
    .TMR_W(TMR_W), .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC),
    .SETTLE_CYC(SETTLE_CYC), .READ_CYC(READ_CYC), .GAP_CYC(GAP_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqData(reqData), .reqCount(reqCount),
    .reqMethod(reqMethod), .pollLimit(pollLimit),
    .statusBits(memDin[DATA_W-1:DATA_W-2]),
    .curAddr(memAddr), .curData(memDout),
    .timerZero(timerZero), .lastByte(lastByte),
    .statusOk(statusOk), .pollLast(pollLast),
    .doneQ(done), .timeoutQ(timeout)
  );

endmodule

// File: tb/nvm_write_poller_tb.sv
module nvm_write_poller_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC  = 3;
  localparam int RECOV_CYC  = 2;
  localparam int SETTLE_CYC = 20;
  localparam int READ_CYC   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [12:0] reqAddr = '0;
  logic [7:0]  reqData = '0;
  logic [6:0]  reqCount = '0;
  logic        reqMethod = 1'b0;
  logic [15:0] pollLimit = '0;
  logic [12:0] memAddr;
  logic [7:0]  memDout;
  logic [7:0]  memDin;
  logic        memCeN, memOeN, memWeN, done, timeout;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_write_poller dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData), .reqCount(reqCount),
    .reqMethod(reqMethod), .pollLimit(pollLimit),
    .memAddr(memAddr), .memDout(memDout), .memDin(memDin),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .done(done), .timeout(timeout)
  );

  // ---------------- memory model ----------------
  logic [7:0]  memArr [256];
  int          busyLeft = 0;
  int          busyCfg  = 0;
  logic        tog = 1'b0;
  logic [7:0]  lastWr = '0;
  logic [12:0] lastWrAddr = '0;

  assign memDin = (busyLeft > 0) ? {~lastWr[7], tog, 6'b0} : memArr[memAddr[7:0]];

  // ---------------- bus monitor (negedge) ----------------
  int   cyc = 0, weLow = 0, oeLow = 0, readCount = 0;
  int   lastWeRise = 0, settleGap = -1;
  int   pulseBad = 0, readBad = 0, addrBad = 0, fightBad = 0;
  logic prevWe = 1'b1, prevOe = 1'b1, firstRdPend = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!memWeN && !memOeN) fightBad++;
    if (!memWeN) weLow = prevWe ? 1 : weLow + 1;
    if (!memOeN) oeLow = prevOe ? 1 : oeLow + 1;
    if (!prevWe && memWeN) begin
      if (weLow != PULSE_CYC || memCeN) pulseBad++;
      memArr[memAddr[7:0]] = memDout;
      lastWr = memDout;
      lastWrAddr = memAddr;
      busyLeft = busyCfg;
      lastWeRise = cyc;
      firstRdPend = 1'b1;
    end
    if (prevOe && !memOeN) begin
      readCount++;
      if (memAddr != lastWrAddr || memCeN || !memWeN) addrBad++;
      if (firstRdPend) begin
        settleGap = cyc - lastWeRise;
        firstRdPend = 1'b0;
      end
    end
    if (!prevOe && memOeN) begin
      if (oeLow != READ_CYC) readBad++;
      if (busyLeft > 0) begin
        busyLeft--;
        tog = ~tog;
      end
    end
    prevWe = memWeN;
    prevOe = memOeN;
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitEnd(output bit gotDone, output bit gotTo);
    gotDone = 1'b0;
    gotTo = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done || timeout) begin
        gotDone = done;
        gotTo = timeout;
        chk(reqReady == 1'b1, "R9 ready with end pulse", int'(reqReady), 1);
        @(negedge clk);
        chk(!done && !timeout, "R9 single-cycle pulse", int'(done | timeout), 0);
        break;
      end
    end
  endtask

  task automatic runOp(input logic [12:0] addr, input int count, input logic [7:0] d0,
                       input logic [7:0] step, input logic method, input int limit,
                       input int busy, output bit gotDone, output bit gotTo);
    busyCfg = busy;
    readCount = 0;
    settleGap = -1;
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      while (!reqReady) @(negedge clk);
      reqValid  = 1'b1;
      reqAddr   = addr;
      reqData   = d0 + 8'(i) * step;
      reqCount  = 7'(count);
      reqMethod = method;
      pollLimit = 16'(limit);
    end
    @(negedge clk);
    reqValid = 1'b0;
    waitEnd(gotDone, gotTo);
  endtask

  task automatic testReset();
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk({memCeN, memOeN, memWeN} == 3'b111, "R1 strobes idle", int'({memCeN, memOeN, memWeN}), 7);
    chk(!done && !timeout, "R1 flags clear", int'({done, timeout}), 0);
  endtask

  task automatic testByteData();
    bit d, t;
    runOp(13'h0123, 1, 8'hA5, 8'h00, 1'b0, 10, 3, d, t);
    chk(d && !t, "R6 byte write completes", int'(d), 1);
    chk(readCount == 4, "R6 reads until bit7 true", readCount, 4);
    chk(memArr[8'h23] == 8'hA5, "R2 byte stored", int'(memArr[8'h23]), 8'hA5);
    chk(settleGap == RECOV_CYC + SETTLE_CYC, "R4 settle gap", settleGap, RECOV_CYC + SETTLE_CYC);
  endtask

  task automatic testByteDataNoBusy();
    bit d, t;
    runOp(13'h0005, 1, 8'h3C, 8'h00, 1'b0, 10, 0, d, t);
    chk(d && readCount == 1, "R6 immediate completion", readCount, 1);
  endtask

  task automatic testPageToggle();
    bit d, t;
    runOp(13'h107E, 4, 8'h10, 8'h11, 1'b1, 10, 2, d, t);
    chk(d && !t, "R7 page write completes", int'(d), 1);
    chk(readCount == 4, "R7 reads until bit6 steady", readCount, 4);
    chk(memArr[8'h7E] == 8'h10, "R3 byte0 at 0x7E", int'(memArr[8'h7E]), 8'h10);
    chk(memArr[8'h7F] == 8'h21, "R3 byte1 at 0x7F", int'(memArr[8'h7F]), 8'h21);
    chk(memArr[8'h40] == 8'h32, "R3 byte2 wraps to 0x40", int'(memArr[8'h40]), 8'h32);
    chk(memArr[8'h41] == 8'h43, "R3 byte3 at 0x41", int'(memArr[8'h41]), 8'h43);
    chk(lastWrAddr == 13'h1041, "R3 page bits kept", int'(lastWrAddr), 13'h1041);
    chk(settleGap == RECOV_CYC + SETTLE_CYC, "R4 settle gap page", settleGap, RECOV_CYC + SETTLE_CYC);
  endtask

  task automatic testToggleNoBusy();
    bit d, t;
    runOp(13'h0200, 1, 8'h77, 8'h00, 1'b1, 10, 0, d, t);
    chk(d && readCount == 2, "R7 first read never completes", readCount, 2);
  endtask

  task automatic testTimeouts();
    bit d, t;
    runOp(13'h0300, 1, 8'h55, 8'h00, 1'b1, 5, 10, d, t);
    chk(t && !d, "R8 toggle timeout", int'(t), 1);
    chk(readCount == 5, "R8 reads at timeout", readCount, 5);
    runOp(13'h0301, 1, 8'h81, 8'h00, 1'b0, 5, 4, d, t);
    chk(d && !t && readCount == 5, "R8 limit just enough", readCount, 5);
    runOp(13'h0302, 1, 8'h81, 8'h00, 1'b0, 4, 4, d, t);
    chk(t && !d && readCount == 4, "R8 limit one short", readCount, 4);
    runOp(13'h0303, 1, 8'h02, 8'h00, 1'b0, 0, 2, d, t);
    chk(t && readCount == 1, "R8 zero limit acts as one", readCount, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) memArr[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testByteData();
    testByteDataNoBusy();
    testPageToggle();
    testToggleNoBusy();
    testTimeouts();
    chk(pulseBad == 0, "R2 write pulse width", pulseBad, 0);
    chk(readBad == 0, "R5 read width", readBad, 0);
    chk(addrBad == 0, "R5 read address and strobes", addrBad, 0);
    chk(fightBad == 0, "R10 no strobe overlap", fightBad, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule